// File: doc/BRIEF.md
# Programmable Flag Offset Loader

This block keeps the almost-empty and almost-full thresholds for a single-clock FIFO whose flags are programmable. Software or a controller reaches the thresholds through the FIFO's own byte-wide data ports. When the load-mode input is held low, a write strobe stores the input byte into one offset register and a read strobe puts one offset register on the data output. Each access then moves on to the next register in a fixed ring of four byte-wide registers. Writes and reads each keep their own position in the ring. When load mode is released, both positions are kept, so a partial load can be paused and later resumed.

The two thresholds are each built from a low byte and a narrow high byte. The width of the high byte follows the FIFO depth. The block compares a supplied occupancy count against the two thresholds and drives the almost-empty and almost-full flags. While load mode is active, it blocks ordinary FIFO data traffic through two permit outputs. A write and a read requested in the same cycle in load mode are both dropped, and the collision is reported for one cycle.

Top module: `pflag_offset_bank`

## Requirements
- R1: After reset both thresholds equal 7. The write and read ring positions point at slot 0. The data output is 0 and the collision output is low.
- R2: The ring order is slot 0 = empty threshold low byte, slot 1 = empty threshold high byte, slot 2 = full threshold low byte, slot 3 = full threshold high byte. A write (load_n, wr_en_n both low, read not requested) stores din into the current write slot at the rising edge and advances the write position by one.
- R3: After slot 3 the write position wraps to slot 0, and the read position wraps in the same way.
- R4: While load_n is high, wr_en_n and din have no effect on the offset registers or ring positions. The next load write continues at the slot after the last one written.
- R5: A read (load_n, rd_en1_n and rd_en2_n all low, write not requested) places the current read slot on dout one edge later and advances the read position. dout holds its value when no read takes place.
- R6: High-byte slots store only the low log2(DEPTH)-8 bits of din (1 bit at DEPTH 512) and read back with the upper bits zero.
- R7: A load-mode cycle that requests both a write and a read changes no register, no ring position and no dout. access_clash is high in the cycle after and low otherwise.
- R8: almost_empty is high exactly when fill_count <= empty threshold.
- R9: almost_full is high exactly when DEPTH - fill_count <= full threshold.
- R10: mem_wr_allow is high only when load_n is high and wr_en_n is low. mem_rd_allow is high only when load_n is high and both read enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both reads and writes |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n | input | 1 | Active-low offset access mode |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en1_n | input | 1 | Active-low read enable, first of two |
| rd_en2_n | input | 1 | Active-low read enable, second of two |
| din | input | 8 | Data input byte |
| fill_count | input | $clog2(DEPTH+1) | Current FIFO occupancy |
| dout | output | 8 | Offset readback byte |
| almost_empty | output | 1 | Occupancy at or below the empty threshold |
| almost_full | output | 1 | Free space at or below the full threshold |
| access_clash | output | 1 | Previous cycle requested a write and a read together |
| mem_wr_allow | output | 1 | Permit for a FIFO data write |
| mem_rd_allow | output | 1 | Permit for a FIFO data read |

## Verification
The bench sweeps every occupancy from empty to full against the default and the loaded thresholds. A comparison that is off by one or uses the wrong threshold then shows as a flag flipping one count early or late. It loads more than four bytes to prove the ring wraps, and it releases load mode in the middle of a sequence while write strobes and odd data keep arriving. A design that restarts at slot 0 or stores the stray data then reads back the wrong bytes. A collision with odd data is followed by a known write and readback, which exposes a design that lets either half of the collision through. Storing all 0xFF in the high slots exposes any upper bits that are not masked.

// File: rtl/pfo_pkg.sv
package pfo_pkg;
    localparam int SLOTS = 4;

    typedef enum logic [1:0] {
        SLOT_E_LO = 2'd0,
        SLOT_E_HI = 2'd1,
        SLOT_F_LO = 2'd2,
        SLOT_F_HI = 2'd3
    } slot_e;
endpackage

// File: rtl/pfo_ring_ptr.sv
module pfo_ring_ptr #(
    parameter int N_SLOTS = 4,
    localparam int PW = $clog2(N_SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [PW-1:0] ptr
);
    logic [PW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (adv) begin
            if (ptr_q == PW'(N_SLOTS - 1)) ptr_d = '0;
            else                            ptr_d = ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    // R3
    ring_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && ptr_q == PW'(N_SLOTS - 1)) |=> ptr_q == '0);
    // R4
    ring_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr_q));
endmodule

// File: rtl/pfo_flag_cmp.sv
module pfo_flag_cmp #(
    parameter int DEPTH = 512,
    parameter int OFS_W = 9,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] fill_count,
    input  logic [OFS_W-1:0] empty_ofs,
    input  logic [OFS_W-1:0] full_ofs,
    output logic             almost_empty,
    output logic             almost_full
);
    localparam logic [CNT_W-1:0] DEPTH_V = CNT_W'(DEPTH);

    logic [CNT_W-1:0] free_cnt;

    always_comb begin
        free_cnt     = DEPTH_V - fill_count;
        almost_empty = fill_count <= CNT_W'(empty_ofs);
        almost_full  = free_cnt <= CNT_W'(full_ofs);
    end

    // R8
    empty_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == '0) |-> almost_empty);
    // R9
    full_at_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == DEPTH_V) |-> almost_full);
endmodule

// File: rtl/pflag_offset_bank.sv
module pflag_offset_bank #(
    parameter int DEPTH   = 512,
    parameter int DEF_OFS = 7,
    localparam int BYTE_W = 8,
    localparam int OFS_W  = $clog2(DEPTH),
    localparam int HI_W   = OFS_W - BYTE_W,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              wr_en_n,
    input  logic              rd_en1_n,
    input  logic              rd_en2_n,
    input  logic [BYTE_W-1:0] din,
    input  logic [CNT_W-1:0]  fill_count,
    output logic [BYTE_W-1:0] dout,
    output logic              almost_empty,
    output logic              almost_full,
    output logic              access_clash,
    output logic              mem_wr_allow,
    output logic              mem_rd_allow
);
    import pfo_pkg::*;

    localparam logic [OFS_W-1:0] DEF_V = OFS_W'(DEF_OFS);

    typedef struct packed {
        logic [BYTE_W-1:0] e_lo;
        logic [HI_W-1:0]   e_hi;
        logic [BYTE_W-1:0] f_lo;
        logic [HI_W-1:0]   f_hi;
        logic [BYTE_W-1:0] dout;
        logic              clash;
    } bank_t;

    bank_t st_d, st_q;

    logic wr_req, rd_req, wr_go, rd_go;
    logic [1:0] wr_slot, rd_slot;
    logic [BYTE_W-1:0] rd_byte;

    always_comb begin
        wr_req = !load_n && !wr_en_n;
        rd_req = !load_n && !rd_en1_n && !rd_en2_n;
        wr_go  = wr_req && !rd_req;
        rd_go  = rd_req && !wr_req;
    end

    pfo_ring_ptr #(.N_SLOTS(SLOTS)) u_wr_ptr (
        .clk(clk), .rst_n(rst_n), .adv(wr_go), .ptr(wr_slot)
    );

    pfo_ring_ptr #(.N_SLOTS(SLOTS)) u_rd_ptr (
        .clk(clk), .rst_n(rst_n), .adv(rd_go), .ptr(rd_slot)
    );

    always_comb begin
        case (slot_e'(rd_slot))
            SLOT_E_LO: rd_byte = st_q.e_lo;
            SLOT_E_HI: rd_byte = BYTE_W'(st_q.e_hi);
            SLOT_F_LO: rd_byte = st_q.f_lo;
            default:   rd_byte = BYTE_W'(st_q.f_hi);
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.clash = wr_req && rd_req;
        if (wr_go) begin
            case (slot_e'(wr_slot))
                SLOT_E_LO: st_d.e_lo = din;
                SLOT_E_HI: st_d.e_hi = din[HI_W-1:0];
                SLOT_F_LO: st_d.f_lo = din;
                default:   st_d.f_hi = din[HI_W-1:0];
            endcase
        end
        if (rd_go) st_d.dout = rd_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.e_lo  <= DEF_V[BYTE_W-1:0];
            st_q.e_hi  <= DEF_V[OFS_W-1:BYTE_W];
            st_q.f_lo  <= DEF_V[BYTE_W-1:0];
            st_q.f_hi  <= DEF_V[OFS_W-1:BYTE_W];
            st_q.dout  <= '0;
            st_q.clash <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    pfo_flag_cmp #(.DEPTH(DEPTH), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .fill_count  (fill_count),
        .empty_ofs   ({st_q.e_hi, st_q.e_lo}),
        .full_ofs    ({st_q.f_hi, st_q.f_lo}),
        .almost_empty(almost_empty),
        .almost_full (almost_full)
    );

    assign dout         = st_q.dout;
    assign access_clash = st_q.clash;
    assign mem_wr_allow = load_n && !wr_en_n;
    assign mem_rd_allow = load_n && !rd_en1_n && !rd_en2_n;

    // R7
    clash_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && rd_req) |=> access_clash);
    // R7
    clash_dout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && rd_req) |=> $stable(dout));
    // R5
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(dout));
    // R10
    load_blocks_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |-> !(mem_wr_allow || mem_rd_allow));
endmodule

// File: tb/tb_pflag_offset_bank.sv
module tb_pflag_offset_bank;
    localparam int DEPTH   = 512;
    localparam int OFS_W   = $clog2(DEPTH);
    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int HI_MASK = (1 << (OFS_W - 8)) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_n = 1'b1, wr_en_n = 1'b1, rd_en1_n = 1'b1, rd_en2_n = 1'b1;
    logic [7:0] din = '0;
    logic [CNT_W-1:0] fill_count = '0;
    logic [7:0] dout;
    logic almost_empty, almost_full, access_clash, mem_wr_allow, mem_rd_allow;

    int n_chk = 0, n_bad = 0;
    int mreg[4];
    int wp = 0, rp = 0;

    always #10 clk = ~clk;

    pflag_offset_bank #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .wr_en_n(wr_en_n),
        .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .din(din),
        .fill_count(fill_count), .dout(dout), .almost_empty(almost_empty),
        .almost_full(almost_full), .access_clash(access_clash),
        .mem_wr_allow(mem_wr_allow), .mem_rd_allow(mem_rd_allow)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int slot_mask(input int s);
        return (s % 2 == 1) ? HI_MASK : 8'hFF;
    endfunction

    task automatic do_write(input int b);
        @(negedge clk);
        load_n = 1'b0; wr_en_n = 1'b0; din = 8'(b);
        #1 chk(mem_wr_allow == 1'b0, "R10 wr in load", int'(mem_wr_allow), 0);
        @(negedge clk);
        wr_en_n = 1'b1; load_n = 1'b1;
        mreg[wp] = b & slot_mask(wp);
        wp = (wp + 1) % 4;
    endtask

    task automatic do_read(input string req);
        int exp;
        exp = mreg[rp];
        @(negedge clk);
        load_n = 1'b0; rd_en1_n = 1'b0; rd_en2_n = 1'b0;
        @(negedge clk);
        rd_en1_n = 1'b1; rd_en2_n = 1'b1; load_n = 1'b1;
        chk(int'(dout) == exp, req, int'(dout), exp);
        rp = (rp + 1) % 4;
    endtask

    task automatic sweep_flags();
        int eo, fo;
        eo = (mreg[1] << 8) | mreg[0];
        fo = (mreg[3] << 8) | mreg[2];
        for (int f = 0; f <= DEPTH; f++) begin
            @(negedge clk);
            fill_count = CNT_W'(f);
            #1;
            chk(almost_empty == (f <= eo), "R8 almost_empty", int'(almost_empty), int'(f <= eo));
            chk(almost_full == ((DEPTH - f) <= fo), "R9 almost_full", int'(almost_full), int'((DEPTH - f) <= fo));
        end
        fill_count = '0;
    endtask

    bit done = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        mreg[0] = 7; mreg[1] = 0; mreg[2] = 7; mreg[3] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(dout == 8'd0, "R1 dout", int'(dout), 0);
        chk(access_clash == 1'b0, "R1 clash", int'(access_clash), 0);
        for (int i = 0; i < 4; i++) do_read("R1 default readback");
        sweep_flags();

        // R2 / R6: full load, high slots with all ones
        do_write(8'h20); do_write(8'hFF); do_write(8'h10); do_write(8'hFF);
        for (int i = 0; i < 4; i++) do_read("R2 R6 ordered readback");
        sweep_flags();

        // R3 wrap back to slot 0
        do_write(8'h33);
        do_read("R3 wrap slot0");

        // R4 pause with stray strobes, then resume
        do_write(8'h44);
        @(negedge clk);
        wr_en_n = 1'b0; din = 8'h99;
        #1 chk(mem_wr_allow == 1'b1, "R10 wr normal", int'(mem_wr_allow), 1);
        rd_en1_n = 1'b0; rd_en2_n = 1'b0;
        #1 chk(mem_rd_allow == 1'b1, "R10 rd normal", int'(mem_rd_allow), 1);
        rd_en1_n = 1'b1;
        #1 chk(mem_rd_allow == 1'b0, "R10 one rd enable", int'(mem_rd_allow), 0);
        rd_en2_n = 1'b1;
        repeat (3) @(negedge clk);
        wr_en_n = 1'b1;
        do_write(8'h55);
        for (int i = 0; i < 4; i++) do_read("R4 resume readback");

        // R7 collision, odd data; ring at write slot 3, read slot 1
        @(negedge clk);
        load_n = 1'b0; wr_en_n = 1'b0; rd_en1_n = 1'b0; rd_en2_n = 1'b0; din = 8'hAB;
        @(negedge clk);
        load_n = 1'b1; wr_en_n = 1'b1; rd_en1_n = 1'b1; rd_en2_n = 1'b1;
        chk(access_clash == 1'b1, "R7 clash raised", int'(access_clash), 1);
        chk(int'(dout) == mreg[0], "R7 dout unchanged", int'(dout), mreg[0]);
        @(negedge clk);
        chk(access_clash == 1'b0, "R7 clash cleared", int'(access_clash), 0);
        do_write(8'h02);
        for (int i = 0; i < 4; i++) do_read("R7 post-clash readback");
        sweep_flags();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule